// File: doc/BRIEF.md
# Byte-addressed load/store unit

This block sits between a core's address-generation stage and a single-port, word-wide synchronous data memory. The core hands it an effective byte address (base plus offset, already summed), an operation code, the store operand and a request-valid strobe. On the request side the unit works without registers. It turns the byte address into a word address and, for stores, drives per-byte write enables and write data steered into the right byte lane. On the response side, one cycle later, it takes the word returned by memory. For a full-word load it passes that word through. For a byte load it picks out the addressed byte and sign-extends it.

A parameter fixes the byte numbering inside a word. In big-endian numbering, byte offset 0 lives in the most significant lane. In little-endian numbering it lives in the least significant lane. Word accesses must be aligned to a multiple of four bytes. A word access with either low address bit set is flagged as misaligned, and neither a write nor a load result is produced for it. Halfword and unaligned word accesses are not handled.

Top module: `lsu_byte_unit`

## Requirements
- R1: `mem_addr` always equals `req_addr` with its two low bits removed (`req_addr[31:2]`).
- R2: A byte load (`req_op`=2'b10) returns, one cycle later on `ld_data`, the addressed byte in bits 7:0, with bits 31:8 all equal to that byte's bit 7.
- R3: A byte store (`req_op`=2'b11) asserts `mem_we`, asserts exactly one `mem_be` bit (the lane of the addressed byte), and places store-operand bits 7:0 on `mem_wdata` in that lane. The other bytes of the memory word stay unchanged.
- R4: An aligned word store (`req_op`=2'b01) asserts `mem_we` with all four `mem_be` bits set and `mem_wdata` equal to `req_wdata`.
- R5: An aligned word load (`req_op`=2'b00) raises `ld_valid` in the following cycle, with `ld_data` equal to the memory word returned in that cycle.
- R6: With `BIG_ENDIAN`=1, byte offset k (`req_addr[1:0]`) uses lane 3-k, where lane n is bits 8n+7:8n, so offset 0 is bits 31:24. With `BIG_ENDIAN`=0, offset k uses lane k, so offset 0 is bits 7:0.
- R7: A word access (op bit 1 = 0) with `req_addr[1:0]` not zero raises `misalign` in the same cycle. It leaves `mem_we` low and all `mem_be` bits low, and it gives no `ld_valid` in the next cycle. Byte accesses never raise `misalign`.
- R8: With `req_valid` low, `mem_we`, `mem_be` and `misalign` are all low, and `ld_valid` is low in the next cycle.
- R9: During and right after reset, `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_op | input | 2 | 00 word load, 01 word store, 10 byte load, 11 byte store |
| req_addr | input | ADDR_W | Effective byte address |
| req_wdata | input | DATA_W | Store operand from the register file |
| mem_addr | output | ADDR_W-2 | Word address to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | DATA_W/8 | Per-byte write enables |
| mem_wdata | output | DATA_W | Lane-steered write data |
| mem_rdata | input | DATA_W | Word returned by memory one cycle after the address |
| misalign | output | 1 | Misaligned word access in this cycle |
| ld_valid | output | 1 | Load result valid this cycle |
| ld_data | output | DATA_W | Loaded word or sign-extended byte |

## Verification
The only state in the block is the captured load kind and lane, so a wrong capture appears at the ports one cycle after the request. A wrong lane selects a neighbouring byte, a wrong kind gives a zero- or non-extended word, and a stale valid produces a phantom result. Store steering errors leave memory corrupt, and a later word load of the same address exposes them. Two instances, one for each byte numbering, run the same traffic against a behavioural memory, and both ports sides are compared on every clock.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   typedef enum logic [1:0] {
      OP_WORD_LD = 2'b00,
      OP_WORD_ST = 2'b01,
      OP_BYTE_LD = 2'b10,
      OP_BYTE_ST = 2'b11
   } lsu_op_e;

   // bit 0 of the code marks a store, bit 1 marks a byte-sized access
   function automatic logic op_is_store(input logic [1:0] op);
      return op[0];
   endfunction

   function automatic logic op_is_byte(input logic [1:0] op);
      return op[1];
   endfunction
endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map #(
   parameter int OFF_W      = 2,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [OFF_W-1:0] byte_off,
   output logic [OFF_W-1:0] lane
);
   generate
      if (BIG_ENDIAN) begin : g_big
         // lane count is a power of two, so (lanes-1-off) is a bitwise inversion
         assign lane = ~byte_off;
      end else begin : g_little
         assign lane = byte_off;
      end
   endgenerate
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int OFF_W = $clog2(BYTES)
) (
   input  logic              wr_en,
   input  logic              is_byte,
   input  logic [OFF_W-1:0]  lane,
   input  logic [DATA_W-1:0] st_data,
   output logic [BYTES-1:0]  be,
   output logic [DATA_W-1:0] wdata
);
   genvar g;
   generate
      for (g = 0; g < BYTES; g++) begin : g_lane
         assign be[g] = wr_en & (~is_byte | (lane == OFF_W'(g)));
         // a byte store repeats the low byte in every lane; the enable picks one
         assign wdata[g*8 +: 8] = is_byte ? st_data[7:0] : st_data[g*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int OFF_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              cap_byte,
   input  logic [OFF_W-1:0]  cap_lane,
   input  logic [DATA_W-1:0] rdata,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data
);
   logic             vld_q;
   logic             byte_q;
   logic [OFF_W-1:0] lane_q;
   logic [7:0]       lanes [BYTES];
   logic [7:0]       pick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         byte_q <= 1'b0;
         lane_q <= '0;
      end else begin
         vld_q <= capture;
         if (capture) begin
            byte_q <= cap_byte;
            lane_q <= cap_lane;
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < BYTES; g++) begin : g_split
         assign lanes[g] = rdata[g*8 +: 8];
      end
   endgenerate

   assign pick     = lanes[lane_q];
   assign ld_valid = vld_q;
   assign ld_data  = byte_q ? {{(DATA_W-8){pick[7]}}, pick} : rdata;
endmodule

// File: rtl/lsu_byte_unit.sv
module lsu_byte_unit
   import lsu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int BYTES     = DATA_W / 8,
   localparam int OFF_W     = $clog2(BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [1:0]              req_op,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [DATA_W-1:0]       req_wdata,
   output logic [ADDR_W-OFF_W-1:0] mem_addr,
   output logic                    mem_we,
   output logic [BYTES-1:0]        mem_be,
   output logic [DATA_W-1:0]       mem_wdata,
   input  logic [DATA_W-1:0]       mem_rdata,
   output logic                    misalign,
   output logic                    ld_valid,
   output logic [DATA_W-1:0]       ld_data
);
   generate
      if (DATA_W < 16 || DATA_W % 8 != 0 || (1 << OFF_W) != BYTES) begin : g_bad_width
         $error("lsu_byte_unit: DATA_W must be a power-of-two count of bytes, at least 2");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("lsu_byte_unit: ADDR_W too small for the byte offset");
      end
   endgenerate

   logic             is_st, is_byte, st_ok, ld_ok;
   logic [OFF_W-1:0] lane;

   assign is_st    = op_is_store(req_op);
   assign is_byte  = op_is_byte(req_op);
   assign misalign = req_valid & ~is_byte & (|req_addr[OFF_W-1:0]);
   assign st_ok    = req_valid & is_st & ~misalign;
   assign ld_ok    = req_valid & ~is_st & ~misalign;
   assign mem_addr = req_addr[ADDR_W-1:OFF_W];
   assign mem_we   = st_ok;

   lsu_lane_map #(.OFF_W(OFF_W), .BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .byte_off (req_addr[OFF_W-1:0]),
      .lane     (lane)
   );

   lsu_store_steer #(.DATA_W(DATA_W)) u_store (
      .wr_en   (st_ok),
      .is_byte (is_byte),
      .lane    (lane),
      .st_data (req_wdata),
      .be      (mem_be),
      .wdata   (mem_wdata)
   );

   lsu_load_extract #(.DATA_W(DATA_W)) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (ld_ok),
      .cap_byte (is_byte),
      .cap_lane (lane),
      .rdata    (mem_rdata),
      .ld_valid (ld_valid),
      .ld_data  (ld_data)
   );

   assert_be_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && req_op == OP_BYTE_ST) |-> $countones(mem_be) == 1);

   assert_word_store_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && req_op == OP_WORD_ST) |-> (mem_be == '1 && mem_wdata == req_wdata));

   assert_misalign_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_we && mem_be == '0));

   assert_misalign_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |=> !ld_valid);

   assert_load_follows_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(req_valid && !req_op[0]));

   assert_byte_sign_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && $past(req_op == OP_BYTE_LD))
         |-> ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}});

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_we && mem_be == '0 && !misalign));
endmodule

// File: tb/lsu_byte_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_byte_unit_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        req_valid;
   logic [1:0]  req_op;
   logic [31:0] req_addr, req_wdata;
   logic [31:0] mem_rdata;
   logic [29:0] be_addr, le_addr;
   logic        be_we, le_we, be_mis, le_mis, be_lv, le_lv;
   logic [3:0]  be_be, le_be;
   logic [31:0] be_wd, le_wd, be_ld, le_ld;

   lsu_byte_unit #(.BIG_ENDIAN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(be_addr),
      .mem_we(be_we), .mem_be(be_be), .mem_wdata(be_wd), .mem_rdata(mem_rdata),
      .misalign(be_mis), .ld_valid(be_lv), .ld_data(be_ld));

   lsu_byte_unit #(.BIG_ENDIAN(1'b0)) dut_le_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(le_addr),
      .mem_we(le_we), .mem_be(le_be), .mem_wdata(le_wd), .mem_rdata(mem_rdata),
      .misalign(le_mis), .ld_valid(le_lv), .ld_data(le_ld));

   // behavioural memory driven by the big-endian instance
   logic [31:0] mem [16];
   always @(posedge clk) begin
      if (be_we)
         for (int b = 0; b < 4; b++)
            if (be_be[b]) mem[be_addr[3:0]][b*8 +: 8] <= be_wd[b*8 +: 8];
      mem_rdata <= mem[be_addr[3:0]];
   end

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] load_exp(input logic [31:0] w, input logic [1:0] op,
                                            input logic [1:0] off, input bit big);
      int lane;
      logic [7:0] b;
      lane = big ? 3 - off : off;
      b = w[lane*8 +: 8];
      return op[1] ? {{24{b[7]}}, b} : w;
   endfunction

   logic        pend_v = 0;
   logic [31:0] pend_big, pend_lit;

   task automatic step(input bit v, input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd);
      bit mis, we;
      logic [3:0] eb, el;
      logic [31:0] w;
      @(negedge clk);
      req_valid = v; req_op = op; req_addr = addr; req_wdata = wd;
      #2;
      mis = v && !op[1] && addr[1:0] != 2'b00;
      we  = v && op[0] && !mis;
      eb  = !we ? 4'h0 : (op[1] ? 4'(1 << (3 - addr[1:0])) : 4'hF);
      el  = !we ? 4'h0 : (op[1] ? 4'(1 << addr[1:0]) : 4'hF);
      chk(be_addr == addr[31:2] && le_addr == addr[31:2], "R1", {2'b0, be_addr}, {2'b0, addr[31:2]});
      chk(be_mis == mis && le_mis == mis, v ? "R7" : "R8", {31'b0, be_mis}, {31'b0, mis});
      chk(be_we == we && le_we == we, op[1] ? "R3" : "R4", {31'b0, be_we}, {31'b0, we});
      chk(be_be == eb, "R6 big lanes", {28'b0, be_be}, {28'b0, eb});
      chk(le_be == el, "R6 little lanes", {28'b0, le_be}, {28'b0, el});
      for (int b = 0; b < 4; b++) begin
         if (eb[b]) chk(be_wd[b*8 +: 8] == (op[1] ? wd[7:0] : wd[b*8 +: 8]),
                        op[1] ? "R3 big data" : "R4 data", be_wd, wd);
         if (el[b]) chk(le_wd[b*8 +: 8] == (op[1] ? wd[7:0] : wd[b*8 +: 8]),
                        op[1] ? "R3 little data" : "R4 data", le_wd, wd);
      end
      chk(be_lv == pend_v && le_lv == pend_v, "R5 ld_valid", {31'b0, be_lv}, {31'b0, pend_v});
      if (pend_v) begin
         chk(be_ld == pend_big, "R2/R5 big load", be_ld, pend_big);
         chk(le_ld == pend_lit, "R2/R5 little load", le_ld, pend_lit);
      end
      w = mem[addr[5:2]];
      pend_v   = v && !op[0] && !mis;
      pend_big = load_exp(w, op, addr[1:0], 1'b1);
      pend_lit = load_exp(w, op, addr[1:0], 1'b0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 32'h0123_4567 ^ (i * 32'h9E37_79B9);
      rst_n = 0; req_valid = 0; req_op = 2'b00; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(be_lv == 0 && le_lv == 0, "R9", {31'b0, be_lv}, 32'h0);
      chk(be_be == 0 && be_we == 0, "R9/R8", {28'b0, be_be}, 32'h0);
      rst_n = 1;
      // R4 word stores, then R5 word loads
      step(1, 2'b01, 32'h00, 32'h8172_F311);
      step(1, 2'b01, 32'h04, 32'h7F80_01FE);
      step(1, 2'b00, 32'h00, 0);
      step(1, 2'b00, 32'h04, 0);
      step(0, 2'b00, 32'h04, 0);       // R8 idle
      // R2/R6 byte loads at every offset, mixed sign bits
      for (int o = 0; o < 8; o++) step(1, 2'b10, 32'(o), 0);
      // R3 byte stores at each offset, then word read-back shows untouched neighbours
      for (int o = 0; o < 4; o++) step(1, 2'b11, 32'(8 + o), 32'hABCD_EF00 | 32'(o * 33 + 5));
      step(1, 2'b00, 32'h08, 0);
      step(1, 2'b11, 32'h0D, 32'h0000_00C3);
      step(1, 2'b00, 32'h0C, 0);
      step(1, 2'b10, 32'h0D, 0);
      // R7 misaligned word accesses, then the word is unchanged
      step(1, 2'b01, 32'h01, 32'hDEAD_BEEF);
      step(1, 2'b00, 32'h02, 0);
      step(1, 2'b01, 32'h07, 32'hDEAD_BEEF);
      step(1, 2'b00, 32'h00, 0);
      step(1, 2'b00, 32'h04, 0);
      // mixed traffic
      for (int i = 0; i < 2000; i++)
         step(($urandom % 5) != 0, 2'($urandom), 32'($urandom % 64), $urandom);
      step(0, 2'b00, 0, 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule